// File: doc/BRIEF.md
# Threshold Lock Detector

This block decides whether a timing-disciplining loop is phase-locked. Once per reference period the loop presents a signed, already limited error value with a one-cycle valid strobe. The block takes the magnitude of that error and compares it with a threshold supplied on an input port. A retriggerable down-counter counts the consecutive periods whose error is within the threshold. When the counter reaches zero, the lock flag is raised.

A single period whose error is outside the threshold reloads the counter to its start value, and the lock flag drops at once. If the flag was set when that happens, a one-cycle lock-lost pulse is emitted. Lock therefore reflects an unbroken run of small-error periods. The block does not produce the error itself.

Top module: `phase_lock_monitor`

## Requirements
- R1: While synchronous active-low reset is applied, and on the first cycle after it, `locked` and `lock_lost` are 0. The run counter is loaded with `RUN_LEN` (default 16), so a full run is needed after reset.
- R2: The comparison uses the absolute value of the two's-complement error. A negative error whose magnitude is within the threshold counts as in band.
- R3: An error whose magnitude is exactly equal to `thresh` counts as in band. Magnitude `thresh`+1 counts as out of band.
- R4: `locked` rises one clock after the `RUN_LEN`-th consecutive in-band strobe, and not earlier.
- R5: An out-of-band strobe reloads the counter. After it, a full `RUN_LEN` in-band strobes are needed again before lock.
- R6: `locked` is 0 one clock after any out-of-band strobe.
- R7: `lock_lost` is a one-cycle pulse. It is high one clock after an out-of-band strobe taken while `locked` was 1, and it is never high otherwise.
- R8: On cycles without `err_valid`, `err_value` and `thresh` are ignored: `locked` holds its value and `lock_lost` is 0.
- R9: The counter saturates at zero. Further in-band strobes keep `locked` at 1.
- R10: `thresh` is sampled on each strobe, so changing it changes how later errors are classified.
- R11: The most negative error value is classified by its true magnitude, 2^(ERR_W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_value | input | ERR_W | Signed limited phase error, two's complement |
| err_valid | input | 1 | One-cycle strobe, once per reference period |
| thresh | input | ERR_W | Unsigned in-band magnitude limit |
| locked | output | 1 | Lock flag |
| lock_lost | output | 1 | One-cycle pulse when a locked loop sees an out-of-band error |

## Verification
The hardest situations to reach are the exact run-length boundary and the edges of the magnitude compare. One is a run that is one strobe short of `RUN_LEN` and is then broken. The others are errors that sit at `thresh`, at `thresh`+1 and at the most negative code. The stimulus builds runs of 15 and 16 strobes separated by idle gaps of varying length, with large garbage on the error bus during those gaps. It then breaks a run partway, re-locks, and walks the threshold across the negative extreme. A behavioural model predicts both outputs on every cycle.

// File: rtl/lockdet_pkg.sv
// Package: shared helpers for the lock detector.
// Assumes two's-complement error words.
package lockdet_pkg;
    // Width needed to hold a count from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/lockdet_mag_cmp.sv
// Module: lockdet_mag_cmp
// Takes the magnitude of a signed error and tests it against an unsigned
// limit. The result is in band when magnitude <= limit. The magnitude is
// held in ERR_W unsigned bits, so the most negative code maps to
// 2^(ERR_W-1) without overflow. Purely combinational.
module lockdet_mag_cmp #(
    parameter int ERR_W = 16
) (
    input  logic signed [ERR_W-1:0] err_in,
    input  logic        [ERR_W-1:0] limit,
    output logic                    in_band
);
    logic [ERR_W-1:0] mag;

    // Absolute value, then magnitude compare.
    always_comb begin
        mag     = err_in[ERR_W-1] ? (~err_in + 1'b1) : err_in;
        in_band = (mag <= limit);
    end
endmodule

// File: rtl/lockdet_run_counter.sv
// Module: lockdet_run_counter
// Retriggerable down-counter of consecutive in-band periods. It is
// evaluated only on strobes. An out-of-band strobe reloads it to RUN_LEN.
// An in-band strobe decrements it, saturating at zero. run_done tells the
// caller that this strobe leaves the count at zero.
// Assumes RUN_LEN >= 1.
module lockdet_run_counter
    import lockdet_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic in_band,
    output logic run_done
);
    localparam int CW = cnt_width(RUN_LEN);
    localparam logic [CW-1:0] START = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;

    // Reload on reset or retrigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= START;
        else if (strobe) begin
            if (!in_band)
                cnt_q <= START;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // The count will be zero after this strobe.
    always_comb run_done = strobe && in_band && (cnt_q <= CW'(1));
endmodule

// File: rtl/phase_lock_monitor.sv
// Module: phase_lock_monitor (top)
// Declares phase lock after RUN_LEN consecutive periods whose absolute
// error is within thresh. Any out-of-band period drops lock and reloads
// the run. If lock was held at that moment, a one-cycle lock_lost pulse
// is emitted. Both outputs are registered and change one clock after the
// strobe that causes them. Assumes err_valid pulses at most once per
// reference period.
module phase_lock_monitor #(
    parameter int ERR_W   = 16,
    parameter int RUN_LEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_value,
    input  logic                    err_valid,
    input  logic        [ERR_W-1:0] thresh,
    output logic                    locked,
    output logic                    lock_lost
);
    logic in_band;
    logic run_done;
    logic locked_q;
    logic lost_q;

    lockdet_mag_cmp #(.ERR_W(ERR_W)) u_cmp (
        .err_in  (err_value),
        .limit   (thresh),
        .in_band (in_band)
    );

    lockdet_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (err_valid),
        .in_band  (in_band),
        .run_done (run_done)
    );

    // Lock flag: set at the end of a run, cleared by an out-of-band strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (err_valid)
            locked_q <= in_band && (locked_q || run_done);
    end

    // Loss pulse: a retrigger taken while locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost_q <= 1'b0;
        else
            lost_q <= err_valid && !in_band && locked_q;
    end

    assign locked    = locked_q;
    assign lock_lost = lost_q;
endmodule

// File: rtl/phase_lock_monitor_chk.sv
// Module: phase_lock_monitor_chk
// Temporal checks on the lock detector ports. It is attached to every
// instance of the top by the bind at the end of this file.
module phase_lock_monitor_chk #(
    parameter int ERR_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [ERR_W-1:0] err_value,
    input logic                    err_valid,
    input logic        [ERR_W-1:0] thresh,
    input logic                    locked,
    input logic                    lock_lost
);
    logic [ERR_W:0] mag_w;
    logic           out_band;

    // Independent wide magnitude for the checks.
    always_comb begin
        mag_w    = err_value[ERR_W-1] ? ({1'b0, {ERR_W{1'b0}}} - {err_value[ERR_W-1], err_value})
                                      : {1'b0, err_value};
        out_band = mag_w > {1'b0, thresh};
    end

    AST_LOST_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |-> ($past(locked) && !locked));                         // R7
    AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |=> !lock_lost);                                         // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> ($stable(locked) && !lock_lost));                   // R8
    AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(err_valid));                               // R4
    AST_BAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && out_band) |=> !locked);                              // R6
    AST_GOOD_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !out_band && locked) |=> locked);                    // R9
endmodule

bind phase_lock_monitor phase_lock_monitor_chk #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_value (err_value),
    .err_valid (err_valid),
    .thresh    (thresh),
    .locked    (locked),
    .lock_lost (lock_lost)
);

// File: tb/phase_lock_monitor_test.sv
// Bench: behavioural model of the lock detector, compared every cycle.
module phase_lock_monitor_test;
    localparam int EW  = 16;
    localparam int RUN = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [EW-1:0] err_value = '0;
    logic                 err_valid = 1'b0;
    logic        [EW-1:0] thresh = 16'd100;
    logic                 locked;
    logic                 lock_lost;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string tag = "R1";

    // Model state.
    int m_cnt = RUN;
    bit m_lk = 1'b0;
    bit m_ll = 1'b0;

    phase_lock_monitor #(.ERR_W(EW), .RUN_LEN(RUN)) uut (
        .clk(clk), .rst_n(rst_n), .err_value(err_value), .err_valid(err_valid),
        .thresh(thresh), .locked(locked), .lock_lost(lock_lost)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Model update at each rising edge, from the inputs held since the last falling edge.
    always @(posedge clk) begin
        longint e;
        longint mag;
        bit     good;
        cycles++;
        if (!rst_n) begin
            m_cnt = RUN; m_lk = 0; m_ll = 0;
        end else begin
            m_ll = 0;
            if (err_valid) begin
                e    = longint'(err_value);
                mag  = (e < 0) ? -e : e;
                good = mag <= longint'(thresh);
                if (good) begin
                    if (m_cnt > 0) m_cnt--;
                    if (m_cnt == 0) m_lk = 1;
                end else begin
                    m_ll  = m_lk;
                    m_cnt = RUN;
                    m_lk  = 0;
                end
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        total++;
        if (locked !== m_lk) begin
            bad++;
            $display("FAIL %s locked: actual=%b expected=%b t=%0t", tag, locked, m_lk, $time);
        end
        total++;
        if (lock_lost !== m_ll) begin
            bad++;
            $display("FAIL %s lock_lost: actual=%b expected=%b t=%0t", tag, lock_lost, m_ll, $time);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One strobe with value v, followed by `gap` idle cycles carrying noise on the bus.
    task automatic strobe(input int v, input int gap);
        err_value = EW'(v);
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
        for (int i = 0; i < gap; i++) begin
            err_value = EW'(16'h7FFF - i * 37);
            @(negedge clk);
        end
    endtask

    // Explicit expectation check on the outputs.
    task automatic expect_out(input string rq, input bit lk, input bit ll);
        total++;
        if (locked !== lk || lock_lost !== ll) begin
            bad++;
            $display("FAIL %s: actual=%b%b expected=%b%b", rq, locked, lock_lost, lk, ll);
        end
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        expect_out("R1", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 0, 0);

        // 15 in-band strobes (some negative), then one at exactly thresh.
        tag = "R2";
        for (int i = 0; i < 15; i++) strobe((i % 2) ? -90 : 50, i % 3);
        expect_out("R4", 0, 0);
        tag = "R3";
        strobe(100, 0);
        expect_out("R4", 1, 0);

        // Saturation, then noisy idle gaps.
        tag = "R9";
        for (int i = 0; i < 5; i++) strobe(-100, 1);
        expect_out("R9", 1, 0);
        tag = "R8";
        err_value = 16'sh7FFF;
        repeat (6) @(negedge clk);
        expect_out("R8", 1, 0);

        // Out of band by one while locked: drop and pulse.
        tag = "R6";
        strobe(-101, 0);
        expect_out("R7", 0, 1);
        @(negedge clk);
        expect_out("R7", 0, 0);
        tag = "R7";
        strobe(500, 2);
        expect_out("R7", 0, 0);

        // A run of 15 is broken, then a fresh run is needed.
        tag = "R5";
        for (int i = 0; i < 15; i++) strobe(i, 1);
        strobe(101, 1);
        for (int i = 0; i < 15; i++) strobe(-i, 0);
        expect_out("R5", 0, 0);
        strobe(0, 0);
        expect_out("R5", 1, 0);

        // Lower the threshold: an error that was in band is now out of band.
        tag = "R10";
        thresh = 16'd20;
        strobe(50, 1);
        expect_out("R10", 0, 0);
        for (int i = 0; i < 16; i++) strobe(-20, 0);
        expect_out("R10", 1, 0);

        // Most negative code against thresholds just below and at 2^15.
        tag = "R11";
        thresh = 16'h7FFF;
        strobe(-32768, 1);
        thresh = 16'h8000;
        for (int i = 0; i < 16; i++) strobe(-32768, 0);
        expect_out("R11", 1, 0);
        thresh = 16'h7FFF;
        strobe(-32768, 0);
        expect_out("R11", 0, 1);

        // Reset in the middle of a run.
        tag = "R1";
        thresh = 16'd100;
        for (int i = 0; i < 10; i++) strobe(3, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 15; i++) strobe(3, 0);
        expect_out("R1", 0, 0);
        strobe(3, 2);
        expect_out("R4", 1, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule